// File: doc/BRIEF.md
# SPI Byte-Memory Command Engine

This block is the serial front end of a 2,048-byte nonvolatile byte array. It connects the four wires of an SPI bus and a pause input to a simple synchronous array port. The SPI clock may idle low or idle high, which are modes 0 and 3. The pins are oversampled by the system clock. For each chip-select window the block deserialises one command byte, an optional two-byte start address and the data bytes that follow. It returns read data and status most significant bit first.

Writes go straight into the array, one strobe per completed byte, with no page buffer and no busy time. The address counter advances after every byte and wraps over the whole array. The engine takes no write-permission decisions itself. It issues pulses for a decoded command, a status byte received and a memory byte received, together with the current address, for a separate protection block. That block returns a permission level that gates the array strobe and supplies the status byte that a status read returns.

The system clock must run at least eight times faster than the SPI clock. Each SPI clock phase must last at least four system clocks.

Top module: `spi_mem_cmd_engine`

## Requirements
- R1: Input bits are taken on rising SPI clock edges, most significant bit first. The first byte in a chip-select window is the command. The known commands are 0x06 (set write enable), 0x04 (clear write enable), 0x05 (status read), 0x01 (status write), 0x03 (memory read) and 0x02 (memory write). A known command gives one `op_done` pulse, with its value on `op_code`. Both clock-idle levels (modes 0 and 3) work.
- R2: For memory write, two address bytes follow the command (high byte first). Only the low 11 bits are used. Every later complete byte gives one `mem_wr_pulse` with that byte on `arr_wdata` and its address on `arr_addr`.
- R3: The address advances by one after every data byte, in both read and write, and wraps from 0x7FF to 0x000.
- R4: For memory read, after the two address bytes `so` returns the array byte at the address, MSB first. Each bit changes on a falling SPI clock edge. Successive bytes come from successive addresses.
- R5: During memory read, the data on `si` after the address has no effect: no memory strobe and no status pulse occur.
- R6: `so_oe` is 0 except while memory-read or status-read data is being returned inside an active chip-select window.
- R7: Status read returns `stat_byte` in the byte after the command. After that byte, `so_oe` stays 0 until chip select rises.
- R8: Status write takes exactly one byte and gives one `sr_wr_pulse` with that byte on `sr_wdata`. Further bytes in the same window are ignored.
- R9: Only one command is accepted per chip-select window. Bytes that follow a set- or clear-write-enable command produce no further `op_done`.
- R10: When chip select rises mid-byte, the partial byte is discarded and nothing is written. The next window starts again at a command byte.
- R11: An unknown command byte produces no pulse and no `op_done`, and keeps `so_oe` at 0 until chip select rises.
- R12: While `hold_n` is 0, SPI clock edges are ignored and `so_oe` is 0. When `hold_n` returns to 1, the transfer continues from the bit where it stopped.
- R13: A memory byte still gives `mem_wr_pulse` and advances the address, but `arr_we` is raised only when `mem_wr_ok` is 1.
- R14: After reset, `so_oe`, `arr_we`, `op_done`, `sr_wr_pulse` and `mem_wr_pulse` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | SPI serial clock |
| cs_n | input | 1 | Chip select, active low |
| si | input | 1 | Serial data in |
| hold_n | input | 1 | Pause input, active low |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Output enable for `so` (0 means high impedance) |
| arr_addr | output | ADDR_W | Array address |
| arr_wdata | output | 8 | Array write data |
| arr_we | output | 1 | Array write strobe |
| arr_rdata | input | 8 | Array read data, one clock after `arr_addr` |
| mem_wr_ok | input | 1 | Protection verdict for the current address |
| stat_byte | input | 8 | Status byte returned by a status read |
| op_done | output | 1 | Pulse when a known command byte is received |
| op_code | output | 8 | Last command byte |
| sr_wr_pulse | output | 1 | Pulse when a status-write byte is received |
| sr_wdata | output | 8 | Received status byte |
| mem_wr_pulse | output | 1 | Pulse when a memory-write byte is received |
| cur_addr | output | ADDR_W | Current byte address |

## Verification
The pins pass through one sampling register, then an edge register, then the stage that acts. So a memory strobe, status pulse or command pulse appears on the third system clock edge after the SPI clock rise that completes a byte. A serial output bit settles on the second edge after an SPI clock fall. The bench drives pins only on falling system clock edges and holds each SPI clock phase for eight system clocks. It reads `so` and `so_oe` at the end of the low phase, well after they have settled. A scoreboard queue holds the expected strobes, and a monitor compares each strobe as it appears. The counts of pulses and output-enable flags are checked after each transaction.

// File: rtl/spi_mem_pkg.sv
package spi_mem_pkg;

    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(BYTE_W);

    localparam logic [BYTE_W-1:0] CMD_WEN_SET = 8'h06;
    localparam logic [BYTE_W-1:0] CMD_WEN_CLR = 8'h04;
    localparam logic [BYTE_W-1:0] CMD_ST_RD   = 8'h05;
    localparam logic [BYTE_W-1:0] CMD_ST_WR   = 8'h01;
    localparam logic [BYTE_W-1:0] CMD_MEM_RD  = 8'h03;
    localparam logic [BYTE_W-1:0] CMD_MEM_WR  = 8'h02;

    typedef enum logic [2:0] {
        PH_CMD,
        PH_ADR_HI,
        PH_ADR_LO,
        PH_WR_DATA,
        PH_RD_DATA,
        PH_ST_IN,
        PH_ST_OUT,
        PH_SINK
    } phase_e;

    typedef struct packed {
        logic sclk;
        logic csn;
        logic hold_n;
        logic si;
    } pin_sample_t;

    function automatic logic cmd_known(input logic [BYTE_W-1:0] c);
        return (c == CMD_WEN_SET) || (c == CMD_WEN_CLR) || (c == CMD_ST_RD) ||
               (c == CMD_ST_WR)   || (c == CMD_MEM_RD)  || (c == CMD_MEM_WR);
    endfunction

    function automatic phase_e cmd_next_phase(input logic [BYTE_W-1:0] c);
        phase_e p;
        unique case (c)
            CMD_ST_RD:              p = PH_ST_OUT;
            CMD_ST_WR:              p = PH_ST_IN;
            CMD_MEM_RD, CMD_MEM_WR: p = PH_ADR_HI;
            default:                p = PH_SINK;
        endcase
        return p;
    endfunction

    function automatic logic phase_drives(input phase_e p);
        return (p == PH_RD_DATA) || (p == PH_ST_OUT);
    endfunction

endpackage

// File: rtl/spi_pin_sampler.sv
module spi_pin_sampler
    import spi_mem_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic sclk,
    input  logic cs_n,
    input  logic hold_n,
    input  logic si,
    output logic edge_rise,
    output logic edge_fall,
    output logic sel_active,
    output logic hold_open,
    output logic si_bit
);
    pin_sample_t pin_q;
    logic        sclk_prev;
    logic        sel_n_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pin_q     <= '{sclk: 1'b0, csn: 1'b1, hold_n: 1'b1, si: 1'b0};
            sclk_prev <= 1'b0;
            sel_n_q   <= 1'b1;
        end else begin
            pin_q     <= '{sclk: sclk, csn: cs_n, hold_n: hold_n, si: si};
            sclk_prev <= pin_q.sclk;
            // chip-select changes are frozen while the transfer is paused
            if (pin_q.hold_n)
                sel_n_q <= pin_q.csn;
        end
    end

    assign sel_active = ~sel_n_q;
    assign hold_open  = pin_q.hold_n;
    assign si_bit     = pin_q.si;
    assign edge_rise  = sel_active & hold_open &  pin_q.sclk & ~sclk_prev;
    assign edge_fall  = sel_active & hold_open & ~pin_q.sclk &  sclk_prev;

endmodule

// File: rtl/spi_rx_shifter.sv
module spi_rx_shifter
    import spi_mem_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sel_active,
    input  logic              edge_rise,
    input  logic              si_bit,
    output logic              byte_done,
    output logic [BYTE_W-1:0] rx_byte,
    output logic [CNT_W-1:0]  bit_idx
);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

    logic [BYTE_W-2:0] shreg;

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg     <= '0;
            bit_idx   <= '0;
            byte_done <= 1'b0;
            rx_byte   <= '0;
        end else begin
            byte_done <= 1'b0;
            if (!sel_active) begin
                // a partial byte is dropped here
                shreg   <= '0;
                bit_idx <= '0;
            end else if (edge_rise) begin
                shreg <= {shreg[BYTE_W-3:0], si_bit};
                if (bit_idx == LAST_BIT) begin
                    bit_idx   <= '0;
                    byte_done <= 1'b1;
                    rx_byte   <= {shreg, si_bit};
                end else begin
                    bit_idx <= bit_idx + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/spi_cmd_ctrl.sv
module spi_cmd_ctrl
    import spi_mem_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel_active,
    input  logic              byte_done,
    input  logic [BYTE_W-1:0] rx_byte,
    output phase_e            phase,
    output logic [BYTE_W-1:0] opcode,
    output logic              op_done,
    output logic              st_pulse,
    output logic [BYTE_W-1:0] st_data,
    output logic              mem_pulse,
    output logic [BYTE_W-1:0] mem_data,
    output logic [ADDR_W-1:0] addr
);
    logic [BYTE_W-1:0] addr_hi;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= PH_CMD;
            opcode    <= '0;
            op_done   <= 1'b0;
            st_pulse  <= 1'b0;
            st_data   <= '0;
            mem_pulse <= 1'b0;
            mem_data  <= '0;
            addr_hi   <= '0;
            addr      <= '0;
        end else begin
            op_done   <= 1'b0;
            st_pulse  <= 1'b0;
            mem_pulse <= 1'b0;
            // a write byte is strobed at its own address, then the counter moves on
            if (mem_pulse)
                addr <= addr + 1'b1;
            if (!sel_active) begin
                phase <= PH_CMD;
            end else if (byte_done) begin
                unique case (phase)
                    PH_CMD: begin
                        opcode  <= rx_byte;
                        op_done <= cmd_known(rx_byte);
                        phase   <= cmd_next_phase(rx_byte);
                    end
                    PH_ADR_HI: begin
                        addr_hi <= rx_byte;
                        phase   <= PH_ADR_LO;
                    end
                    PH_ADR_LO: begin
                        addr  <= ADDR_W'({addr_hi, rx_byte});
                        phase <= (opcode == CMD_MEM_WR) ? PH_WR_DATA : PH_RD_DATA;
                    end
                    PH_WR_DATA: begin
                        mem_data  <= rx_byte;
                        mem_pulse <= 1'b1;
                    end
                    PH_RD_DATA: begin
                        addr <= addr + 1'b1;
                    end
                    PH_ST_IN: begin
                        st_data  <= rx_byte;
                        st_pulse <= 1'b1;
                        phase    <= PH_SINK;
                    end
                    PH_ST_OUT: begin
                        phase <= PH_SINK;
                    end
                    default: begin
                        phase <= PH_SINK;
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/spi_tx_serializer.sv
module spi_tx_serializer
    import spi_mem_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sel_active,
    input  logic              edge_fall,
    input  logic              drive,
    input  logic [CNT_W-1:0]  bit_idx,
    input  logic [BYTE_W-1:0] src_byte,
    output logic              so_bit
);
    logic [BYTE_W-2:0] txreg;

    always_ff @(posedge clk) begin
        if (rst) begin
            txreg  <= '0;
            so_bit <= 1'b0;
        end else if (!sel_active) begin
            txreg  <= '0;
            so_bit <= 1'b0;
        end else if (edge_fall && drive) begin
            if (bit_idx == '0) begin
                so_bit <= src_byte[BYTE_W-1];
                txreg  <= src_byte[BYTE_W-2:0];
            end else begin
                so_bit <= txreg[BYTE_W-2];
                txreg  <= {txreg[BYTE_W-3:0], 1'b0};
            end
        end
    end

endmodule

// File: rtl/spi_mem_cmd_engine.sv
module spi_mem_cmd_engine
    import spi_mem_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sclk,
    input  logic              cs_n,
    input  logic              si,
    input  logic              hold_n,
    output logic              so,
    output logic              so_oe,
    output logic [ADDR_W-1:0] arr_addr,
    output logic [7:0]        arr_wdata,
    output logic              arr_we,
    input  logic [7:0]        arr_rdata,
    input  logic              mem_wr_ok,
    input  logic [7:0]        stat_byte,
    output logic              op_done,
    output logic [7:0]        op_code,
    output logic              sr_wr_pulse,
    output logic [7:0]        sr_wdata,
    output logic              mem_wr_pulse,
    output logic [ADDR_W-1:0] cur_addr
);
    logic              edge_rise;
    logic              edge_fall;
    logic              sel_active;
    logic              hold_open;
    logic              si_bit;
    logic              byte_done;
    logic [BYTE_W-1:0] rx_byte;
    logic [CNT_W-1:0]  bit_idx;
    phase_e            phase;
    logic              drive;
    logic [BYTE_W-1:0] src_byte;

    spi_pin_sampler u_sampler (
        .clk        (clk),
        .rst        (rst),
        .sclk       (sclk),
        .cs_n       (cs_n),
        .hold_n     (hold_n),
        .si         (si),
        .edge_rise  (edge_rise),
        .edge_fall  (edge_fall),
        .sel_active (sel_active),
        .hold_open  (hold_open),
        .si_bit     (si_bit)
    );

    spi_rx_shifter u_rx (
        .clk        (clk),
        .rst        (rst),
        .sel_active (sel_active),
        .edge_rise  (edge_rise),
        .si_bit     (si_bit),
        .byte_done  (byte_done),
        .rx_byte    (rx_byte),
        .bit_idx    (bit_idx)
    );

    spi_cmd_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .sel_active (sel_active),
        .byte_done  (byte_done),
        .rx_byte    (rx_byte),
        .phase      (phase),
        .opcode     (op_code),
        .op_done    (op_done),
        .st_pulse   (sr_wr_pulse),
        .st_data    (sr_wdata),
        .mem_pulse  (mem_wr_pulse),
        .mem_data   (arr_wdata),
        .addr       (cur_addr)
    );

    assign drive    = phase_drives(phase);
    assign src_byte = (phase == PH_ST_OUT) ? stat_byte : arr_rdata;

    spi_tx_serializer u_tx (
        .clk        (clk),
        .rst        (rst),
        .sel_active (sel_active),
        .edge_fall  (edge_fall),
        .drive      (drive),
        .bit_idx    (bit_idx),
        .src_byte   (src_byte),
        .so_bit     (so)
    );

    assign so_oe    = drive & sel_active & hold_open;
    assign arr_addr = cur_addr;
    assign arr_we   = mem_wr_pulse & mem_wr_ok;

endmodule

// File: rtl/spi_mem_cmd_engine_chk.sv
module spi_mem_cmd_engine_chk #(
    parameter int ADDR_W = 11
) (
    input logic              clk,
    input logic              rst,
    input logic              hold_n,
    input logic              so_oe,
    input logic              arr_we,
    input logic              op_done,
    input logic              sr_wr_pulse,
    input logic              mem_wr_pulse,
    input logic [ADDR_W-1:0] cur_addr
);
    AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        arr_we |=> !arr_we);                                                   // R2
    AST_ADDR_WRAP: assert property (@(posedge clk) disable iff (rst)
        (mem_wr_pulse && (cur_addr == {ADDR_W{1'b1}})) |=> (cur_addr == '0)); // R3
    AST_NO_DRIVE_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
        mem_wr_pulse |-> !so_oe);                                              // R6
    AST_ST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        sr_wr_pulse |=> !sr_wr_pulse);                                         // R8
    AST_ST_NOT_WITH_MEM: assert property (@(posedge clk) disable iff (rst)
        sr_wr_pulse |-> !mem_wr_pulse);                                        // R8
    AST_OP_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        op_done |=> !op_done);                                                 // R9
    AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (rst)
        so_oe |-> $past(hold_n));                                              // R12
endmodule

bind spi_mem_cmd_engine spi_mem_cmd_engine_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .hold_n       (hold_n),
    .so_oe        (so_oe),
    .arr_we       (arr_we),
    .op_done      (op_done),
    .sr_wr_pulse  (sr_wr_pulse),
    .mem_wr_pulse (mem_wr_pulse),
    .cur_addr     (cur_addr)
);

// File: tb/spi_mem_cmd_engine_tb_top.sv
module spi_mem_cmd_engine_tb_top;
    localparam int AW = 11;
    localparam int HALF = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          sclk = 1'b0;
    logic          cs_n = 1'b1;
    logic          si = 1'b0;
    logic          hold_n = 1'b1;
    logic          mem_wr_ok = 1'b1;
    logic [7:0]    stat_byte = 8'h8C;
    logic [7:0]    arr_rdata;
    logic          so, so_oe, arr_we, op_done, sr_wr_pulse, mem_wr_pulse;
    logic [AW-1:0] arr_addr, cur_addr;
    logic [7:0]    arr_wdata, op_code, sr_wdata;

    always #2 clk = ~clk;

    spi_mem_cmd_engine #(.ADDR_W(AW)) dut_i (
        .clk(clk), .rst(rst), .sclk(sclk), .cs_n(cs_n), .si(si), .hold_n(hold_n),
        .so(so), .so_oe(so_oe), .arr_addr(arr_addr), .arr_wdata(arr_wdata),
        .arr_we(arr_we), .arr_rdata(arr_rdata), .mem_wr_ok(mem_wr_ok),
        .stat_byte(stat_byte), .op_done(op_done), .op_code(op_code),
        .sr_wr_pulse(sr_wr_pulse), .sr_wdata(sr_wdata),
        .mem_wr_pulse(mem_wr_pulse), .cur_addr(cur_addr)
    );

    // array model behind the synchronous port
    logic [7:0] mem    [0:2047];
    logic [7:0] shadow [0:2047];
    always @(posedge clk) begin
        if (arr_we) mem[arr_addr] <= arr_wdata;
        arr_rdata <= mem[arr_addr];
    end

    int n_chk = 0, n_bad = 0;
    int op_cnt = 0, sr_cnt = 0, pulse_cnt = 0;
    logic [7:0] last_op = 8'h00, last_sr = 8'h00;
    logic oe_flag = 1'b0, hold_oe = 1'b0;
    bit done = 1'b0;
    logic [18:0] exp_q[$];

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // monitor: pops the scoreboard on every strobe
    always @(negedge clk) begin
        if (!rst) begin
            if (op_done) begin op_cnt++; last_op = op_code; end
            if (sr_wr_pulse) begin sr_cnt++; last_sr = sr_wdata; end
            if (mem_wr_pulse) pulse_cnt++;
            if (arr_we) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R2", "unexpected strobe addr", int'(arr_addr), 0);
                end else begin
                    logic [18:0] e;
                    e = exp_q.pop_front();
                    chk({arr_addr, arr_wdata} == e, "R2", "strobe addr/data",
                        int'({arr_addr, arr_wdata}), int'(e));
                end
            end
        end
    end

    task automatic half();
        repeat (HALF) @(negedge clk);
    endtask

    task automatic xfer(input logic [7:0] tx, input int hold_bit, output logic [7:0] rx);
        for (int i = 7; i >= 0; i--) begin
            sclk = 1'b0;
            si = tx[i];
            half();
            if (i == hold_bit) begin
                hold_n = 1'b0;
                half();
                for (int k = 0; k < 3; k++) begin
                    sclk = 1'b1; si = ~si;
                    half();
                    if (so_oe) hold_oe = 1'b1;
                    sclk = 1'b0;
                    half();
                    if (so_oe) hold_oe = 1'b1;
                end
                si = tx[i];
                hold_n = 1'b1;
                half();
            end
            rx[i] = so;
            if (so_oe) oe_flag = 1'b1;
            sclk = 1'b1;
            half();
        end
    endtask

    task automatic put(input logic [7:0] tx);
        logic [7:0] r;
        xfer(tx, -1, r);
    endtask

    task automatic start(input bit m3);
        sclk = m3;
        half();
        cs_n = 1'b0;
        half();
    endtask

    task automatic stop(input bit m3);
        if (!m3) sclk = 1'b0;
        half();
        cs_n = 1'b1;
        half();
        half();
    endtask

    task automatic expect_wr(input logic [AW-1:0] a, input logic [7:0] d);
        if (mem_wr_ok) begin
            exp_q.push_back({a, d});
            shadow[a] = d;
        end
    endtask

    task automatic wr_burst(input bit m3, input logic [15:0] a, input int n,
                            input logic [7:0] base);
        start(m3);
        put(8'h02); put(a[15:8]); put(a[7:0]);
        for (int k = 0; k < n; k++) begin
            logic [7:0] d;
            d = base + 8'(k * 37);
            expect_wr(AW'(a[AW-1:0] + AW'(k)), d);
            put(d);
        end
        stop(m3);
    endtask

    task automatic rd_check(input bit m3, input logic [15:0] a, input int n,
                            input string req);
        logic [7:0] r;
        start(m3);
        put(8'h03); put(a[15:8]); put(a[7:0]);
        for (int k = 0; k < n; k++) begin
            logic [AW-1:0] ea;
            ea = AW'(a[AW-1:0] + AW'(k));
            xfer(8'(8'hF0 ^ k), -1, r);  // noise on si must not write
            chk(r == shadow[ea], req, "read byte", int'(r), int'(shadow[ea]));
        end
        stop(m3);
    endtask

    initial begin
        logic [7:0] r;
        int p0, o0, s0;
        for (int i = 0; i < 2048; i++) begin
            mem[i] <= 8'(i * 7 + 3);
            shadow[i] = 8'(i * 7 + 3);
        end
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R14 reset state
        chk(!so_oe && !arr_we && !op_done && !sr_wr_pulse && !mem_wr_pulse, "R14",
            "idle outputs", int'({so_oe, arr_we, op_done, sr_wr_pulse, mem_wr_pulse}), 0);

        // R1 set write enable, R9 extra byte ignored
        o0 = op_cnt;
        start(0); put(8'h06); put(8'h02); put(8'h03); stop(0);
        chk(op_cnt == o0 + 1, "R9", "commands per window", op_cnt - o0, 1);
        chk(last_op == 8'h06, "R1", "op_code", int'(last_op), 8'h06);
        start(0); put(8'h04); stop(0);
        chk(last_op == 8'h04, "R1", "op_code clear", int'(last_op), 8'h04);

        // R2 R3 R6 write burst, top address bits ignored
        oe_flag = 1'b0;
        wr_burst(0, 16'hF812, 3, 8'hA5);
        chk(!oe_flag, "R6", "oe during write", int'(oe_flag), 0);
        chk(!so_oe, "R6", "oe after window", int'(so_oe), 0);
        // R3 wrap on write
        wr_burst(0, 16'h07FE, 3, 8'h11);
        chk(mem[0] == shadow[0], "R3", "wrapped byte at 0", int'(mem[0]), int'(shadow[0]));
        // R4 R5 read back, then read across the wrap
        p0 = pulse_cnt; s0 = sr_cnt;
        rd_check(0, 16'h0012, 3, "R4");
        rd_check(0, 16'h07FF, 2, "R3");
        chk(pulse_cnt == p0 && sr_cnt == s0, "R5", "pulses during read",
            pulse_cnt - p0 + sr_cnt - s0, 0);

        // R1 mode 3 write and read
        wr_burst(1, 16'h0300, 2, 8'h40);
        rd_check(1, 16'h0300, 2, "R1");

        // R7 status read
        start(0); put(8'h05);
        oe_flag = 1'b0;
        xfer(8'h00, -1, r);
        chk(r == 8'h8C, "R7", "status byte", int'(r), 8'h8C);
        chk(oe_flag, "R7", "oe while status out", int'(oe_flag), 1);
        oe_flag = 1'b0;
        put(8'h00);
        chk(!oe_flag, "R7", "oe after status byte", int'(oe_flag), 0);
        stop(0);

        // R8 status write, one byte only
        s0 = sr_cnt;
        start(0); put(8'h01); put(8'h84); put(8'h00); stop(0);
        chk(sr_cnt == s0 + 1, "R8", "status pulses", sr_cnt - s0, 1);
        chk(last_sr == 8'h84, "R8", "status data", int'(last_sr), 8'h84);

        // R10 partial byte discarded
        p0 = pulse_cnt;
        start(0); put(8'h02); put(8'h05); put(8'h00);
        for (int i = 0; i < 5; i++) begin
            sclk = 1'b0; si = 1'b1; half(); sclk = 1'b1; half();
        end
        stop(0);
        chk(pulse_cnt == p0, "R10", "pulses for partial byte", pulse_cnt - p0, 0);
        o0 = op_cnt;
        start(0); put(8'h06); stop(0);
        chk(op_cnt == o0 + 1 && last_op == 8'h06, "R10", "fresh command after cut",
            int'(last_op), 8'h06);
        rd_check(0, 16'h0500, 1, "R10");

        // R11 unknown command
        o0 = op_cnt; p0 = pulse_cnt; s0 = sr_cnt;
        oe_flag = 1'b0;
        start(0); put(8'hAB); put(8'h03); put(8'h00); put(8'h00); stop(0);
        chk(op_cnt == o0 && pulse_cnt == p0 && sr_cnt == s0, "R11", "pulses",
            op_cnt - o0 + pulse_cnt - p0 + sr_cnt - s0, 0);
        chk(!oe_flag, "R11", "oe after unknown", int'(oe_flag), 0);

        // R12 pause mid-bit during write and during read
        hold_oe = 1'b0;
        start(0); put(8'h02); put(8'h04); put(8'h20);
        expect_wr(11'h420, 8'hC3);
        xfer(8'hC3, 3, r);
        stop(0);
        chk(mem[11'h420] == 8'hC3, "R12", "byte across pause", int'(mem[11'h420]), 8'hC3);
        start(0); put(8'h03); put(8'h04); put(8'h20);
        xfer(8'h00, 4, r);
        stop(0);
        chk(r == 8'hC3, "R12", "read across pause", int'(r), 8'hC3);
        chk(!hold_oe, "R12", "oe while paused", int'(hold_oe), 0);

        // R13 permission denied: pulse yes, strobe no
        p0 = pulse_cnt;
        mem_wr_ok = 1'b0;
        wr_burst(0, 16'h0600, 2, 8'h77);
        mem_wr_ok = 1'b1;
        chk(pulse_cnt == p0 + 2, "R13", "pulses when denied", pulse_cnt - p0, 2);
        rd_check(0, 16'h0600, 2, "R13");

        chk(exp_q.size() == 0, "R2", "strobes outstanding", exp_q.size(), 0);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL R1 watchdog: actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule